// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block is the host-side register file for a single PS/2 keyboard or mouse port. A processor reaches it through a simple word-addressed slave with a 12-bit byte address, separate read and write strobes and 32-bit data. On the device side it sees a level that says a received byte is waiting, together with that byte. It hands the byte to the host on a data-register read and acknowledges it with a one-cycle pop strobe. A host write to the data register becomes a one-cycle transmit strobe carrying the low byte.

The register window holds a control word, a status word, the data port, a clock-divisor word and an interrupt-status word. Eight read-only identification bytes sit at the top of the 4 KB window. The divisor is kept as storage only. The single interrupt line is a level derived from two control bits and the receive-pending input. Serial line timing and the port enable are handled elsewhere.

Top module: `ps2_port_regs`

## Requirements
- R1: After reset the control and divisor registers and the last received byte read as zero, `irq` is low, and `bus_rdata`, `dev_rx_pop` and `dev_tx_valid` are zero.
- R2: Word index 0 (control) and word index 3 (divisor) are word index = `bus_addr[11:2]`. Each stores a full 32-bit write and reads back exactly the value last written.
- R3: `irq` equals (control bit 3) OR (control bit 4 AND `dev_rx_pending`). It follows a control write from the next cycle and a change of `dev_rx_pending` in the same cycle.
- R4: A read of word index 1 (status) returns bit 6 = 1, bit 4 = `dev_rx_pending`, bit 2 = XOR of all eight bits of the last latched byte, and zero in every other bit.
- R5: A read of word index 2 (data) while `dev_rx_pending` is high raises `dev_rx_pop` for that one access cycle, latches `dev_rx_byte`, and returns that byte in bits 7:0 with zeros above.
- R6: A read of word index 2 while `dev_rx_pending` is low returns the previously latched byte, leaves `dev_rx_pop` low and leaves the latched byte unchanged.
- R7: A read of word index 4 (interrupt status) returns bit 1 = 1, bit 0 = `dev_rx_pending`, and zero elsewhere.
- R8: A write to word index 2 raises `dev_tx_valid` for that access cycle with `dev_tx_byte` = `bus_wdata[7:0]`. No other access raises `dev_tx_valid`.
- R9: Writes to word index 1, word index 4 or any unmapped address change no register and produce no transmit strobe.
- R10: Reads at byte addresses 0xFE0 to 0xFFF return an identification byte selected by (address - 0xFE0) >> 2. The bytes in that order are 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Reads at any other address outside word indexes 0 to 4 return zero.
- R12: `bus_rdata` is registered. It shows the result of a read in the cycle after the access and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dev_rx_pending | input | 1 | Device has a received byte waiting |
| dev_rx_byte | input | 8 | Byte offered by the device |
| dev_rx_pop | output | 1 | One-cycle acknowledge that the byte was taken |
| dev_tx_valid | output | 1 | One-cycle transmit strobe |
| dev_tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The assertions watch the rules that hold on every cycle. A pop strobe must coincide with a pending data read and is followed by that byte on the read bus. A transmit strobe mirrors a data-register write. The status word has its fixed bits. The interrupt level tracks the last control write. Read data holds while no read is issued. Some behaviour only the bench scenarios can show: the parity bit computed from a byte latched earlier, the old byte returned again when nothing is pending, the full storage of control and divisor across ignored writes, the identification bytes, and the clearing effect of a reset applied mid-run.

// File: rtl/ps2_port_pkg.sv
package ps2_port_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  // register selector produced by the address decoder
  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_DATA  = 3'd2,
    SEL_DIV   = 3'd3,
    SEL_ISTAT = 3'd4,
    SEL_ID    = 3'd5,
    SEL_NONE  = 3'd6
  } reg_sel_e;

  // control bits that feed the interrupt
  localparam int CTRL_FORCE_BIT = 3;
  localparam int CTRL_RXIE_BIT  = 4;

  // status bit positions
  localparam int STAT_PAR_BIT  = 2;
  localparam int STAT_FULL_BIT = 4;
  localparam int STAT_TXE_BIT  = 6;

  // interrupt status bit positions
  localparam int ISTAT_RX_BIT = 0;
  localparam int ISTAT_TX_BIT = 1;

  function automatic logic [BYTE_W-1:0] id_byte(input logic [2:0] idx);
    logic [BYTE_W-1:0] b;
    case (idx)
      3'd0:    b = 8'h50;
      3'd1:    b = 8'h10;
      3'd2:    b = 8'h04;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ps2_port_decode.sv
module ps2_port_decode
  import ps2_port_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel,
  output logic [2:0]    id_idx
);

  localparam int WORD_W  = AW - 2;
  localparam int ID_LO   = 5;          // ID window spans 32 bytes
  localparam int ID_TOPW = AW - ID_LO;

  logic [WORD_W-1:0] word_idx;
  logic              in_id_win;

  assign word_idx  = addr[AW-1:2];
  assign in_id_win = &addr[AW-1:ID_LO];
  assign id_idx    = addr[ID_LO-1:2];

  always_comb begin
    if (in_id_win) begin
      sel = SEL_ID;
    end else begin
      case (word_idx)
        WORD_W'(0): sel = SEL_CTRL;
        WORD_W'(1): sel = SEL_STAT;
        WORD_W'(2): sel = SEL_DATA;
        WORD_W'(3): sel = SEL_DIV;
        WORD_W'(4): sel = SEL_ISTAT;
        default:    sel = SEL_NONE;
      endcase
    end
  end

  logic unused_topw;
  assign unused_topw = (ID_TOPW > 0);

endmodule

// File: rtl/ps2_port_cfg_regs.sv
module ps2_port_cfg_regs
  import ps2_port_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_div,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] div_q
);

  logic [DW-1:0] ctrl_d;
  logic [DW-1:0] div_d;

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    if (wr_ctrl) ctrl_d = wdata;
    if (wr_div)  div_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_div)  div_q  <= div_d;
    end
  end

endmodule

// File: rtl/ps2_port_rx_path.sv
module ps2_port_rx_path
  import ps2_port_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_data,
  input  logic          rx_pending,
  input  logic [BW-1:0] rx_byte,
  output logic          pop,
  output logic [BW-1:0] data_view,
  output logic          parity
);

  logic [BW-1:0] last_q;
  logic [BW-1:0] last_d;
  logic          take;

  assign take = rd_data & rx_pending;
  assign pop  = take;

  always_comb begin
    last_d = last_q;
    if (take) last_d = rx_byte;
  end

  // value returned by a data read in this cycle
  assign data_view = take ? rx_byte : last_q;

  // parity is formed from the stored byte by a folding chain
  logic [BW-1:0] fold;
  assign fold[0] = last_q[0];
  for (genvar i = 1; i < BW; i++) begin : g_fold
    assign fold[i] = fold[i-1] ^ last_q[i];
  end
  assign parity = fold[BW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (take) begin
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/ps2_port_regs.sv
module ps2_port_regs
  import ps2_port_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          dev_rx_pending,
  input  logic [BW-1:0] dev_rx_byte,
  output logic          dev_rx_pop,
  output logic          dev_tx_valid,
  output logic [BW-1:0] dev_tx_byte,
  output logic          irq
);

  reg_sel_e      sel;
  logic [2:0]    id_idx;
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] div_q;
  logic [BW-1:0] data_view;
  logic          parity;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_d;
  logic [DW-1:0] rdata_q;

  ps2_port_decode #(.AW(AW)) u_decode (
    .addr   (bus_addr),
    .sel    (sel),
    .id_idx (id_idx)
  );

  ps2_port_cfg_regs #(.DW(DW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (bus_wr && sel == SEL_CTRL),
    .wr_div  (bus_wr && sel == SEL_DIV),
    .wdata   (bus_wdata),
    .ctrl_q  (ctrl_q),
    .div_q   (div_q)
  );

  ps2_port_rx_path #(.BW(BW)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_data    (bus_rd && sel == SEL_DATA),
    .rx_pending (dev_rx_pending),
    .rx_byte    (dev_rx_byte),
    .pop        (dev_rx_pop),
    .data_view  (data_view),
    .parity     (parity)
  );

  // transmit path: data-register write passes straight through
  assign dev_tx_valid = bus_wr && sel == SEL_DATA;
  assign dev_tx_byte  = bus_wdata[BW-1:0];

  // interrupt level
  assign irq = ctrl_q[CTRL_FORCE_BIT] | (ctrl_q[CTRL_RXIE_BIT] & dev_rx_pending);

  // read multiplexer
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_STAT: begin
        rd_mux[STAT_TXE_BIT]  = 1'b1;
        rd_mux[STAT_FULL_BIT] = dev_rx_pending;
        rd_mux[STAT_PAR_BIT]  = parity;
      end
      SEL_DATA:  rd_mux[BW-1:0] = data_view;
      SEL_DIV:   rd_mux = div_q;
      SEL_ISTAT: begin
        rd_mux[ISTAT_TX_BIT] = 1'b1;
        rd_mux[ISTAT_RX_BIT] = dev_rx_pending;
      end
      SEL_ID:    rd_mux[BW-1:0] = id_byte(id_idx);
      default:   rd_mux = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/ps2_port_regs_chk.sv
module ps2_port_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        dev_rx_pending,
  input logic [7:0]  dev_rx_byte,
  input logic        dev_rx_pop,
  input logic        dev_tx_valid,
  input logic [7:0]  dev_tx_byte,
  input logic        irq
);

  logic rd_stat, rd_data, wr_ctrl, wr_data, rd_id0;
  assign rd_stat = bus_rd && bus_addr[11:2] == 10'd1;
  assign rd_data = bus_rd && bus_addr[11:2] == 10'd2;
  assign wr_ctrl = bus_wr && bus_addr[11:2] == 10'd0;
  assign wr_data = bus_wr && bus_addr[11:2] == 10'd2;
  assign rd_id0  = bus_rd && bus_addr == 12'hFE0;

  assert_pop_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rx_pop |-> (rd_data && dev_rx_pending));

  assert_pop_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rx_pop |=> (bus_rdata == {24'd0, $past(dev_rx_byte)}));

  assert_no_pop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !dev_rx_pending) |-> !dev_rx_pop);

  assert_tx_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid |-> (wr_data && dev_tx_byte == bus_wdata[7:0]));

  assert_tx_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |-> dev_tx_valid);

  assert_status_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (bus_rdata[6] && !bus_rdata[5] && !bus_rdata[3]
                 && bus_rdata[1:0] == 2'b00 && bus_rdata[31:7] == 25'd0
                 && bus_rdata[4] == $past(dev_rx_pending)));

  assert_irq_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (irq == ($past(bus_wdata[3]) || ($past(bus_wdata[4]) && dev_rx_pending))));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_id_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id0 |=> (bus_rdata == 32'h50));

endmodule

bind ps2_port_regs ps2_port_regs_chk u_chk (.*);

// File: tb/ps2_port_regs_bench.sv
module ps2_port_regs_bench;

  typedef struct packed {
    bit        wr;
    bit [11:0] addr;
    bit [31:0] wdata;
    bit        pend;
    bit [7:0]  rxb;
    bit [31:0] exp;
    bit [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0,          1'b0, 8'h00, 32'h0,          8'd1},  // R1 ctrl
    '{1'b0, 12'h00C, 32'h0,          1'b0, 8'h00, 32'h0,          8'd1},  // R1 div
    '{1'b1, 12'h000, 32'hA5A5_0004,  1'b0, 8'h00, 32'h0,          8'd2},
    '{1'b0, 12'h000, 32'h0,          1'b0, 8'h00, 32'hA5A5_0004,  8'd2},  // R2
    '{1'b1, 12'h00C, 32'h1234_5678,  1'b0, 8'h00, 32'h0,          8'd2},
    '{1'b0, 12'h00C, 32'h0,          1'b0, 8'h00, 32'h1234_5678,  8'd2},  // R2
    '{1'b0, 12'h004, 32'h0,          1'b0, 8'h00, 32'h40,         8'd4},  // R4
    '{1'b0, 12'h008, 32'h0,          1'b1, 8'h07, 32'h07,         8'd5},  // R5
    '{1'b0, 12'h004, 32'h0,          1'b0, 8'h00, 32'h44,         8'd4},  // R4 odd parity
    '{1'b0, 12'h004, 32'h0,          1'b1, 8'h00, 32'h54,         8'd4},  // R4 full
    '{1'b0, 12'h008, 32'h0,          1'b0, 8'h99, 32'h07,         8'd6},  // R6
    '{1'b0, 12'h008, 32'h0,          1'b1, 8'hC3, 32'hC3,         8'd5},  // R5
    '{1'b0, 12'h004, 32'h0,          1'b0, 8'h00, 32'h40,         8'd4},  // R4 even parity
    '{1'b0, 12'h010, 32'h0,          1'b1, 8'h00, 32'h3,          8'd7},  // R7
    '{1'b0, 12'h010, 32'h0,          1'b0, 8'h00, 32'h2,          8'd7},  // R7
    '{1'b1, 12'h008, 32'h0000_01E6,  1'b0, 8'h00, 32'h0,          8'd8},  // R8
    '{1'b1, 12'h004, 32'hFFFF_FFFF,  1'b0, 8'h00, 32'h0,          8'd9},  // R9
    '{1'b1, 12'h010, 32'hFFFF_FFFF,  1'b0, 8'h00, 32'h0,          8'd9},  // R9
    '{1'b1, 12'h020, 32'hFFFF_FFFF,  1'b0, 8'h00, 32'h0,          8'd9},  // R9
    '{1'b0, 12'h000, 32'h0,          1'b0, 8'h00, 32'hA5A5_0004,  8'd9},  // R9 ctrl kept
    '{1'b0, 12'hFE0, 32'h0,          1'b0, 8'h00, 32'h50,         8'd10}, // R10
    '{1'b0, 12'hFF0, 32'h0,          1'b0, 8'h00, 32'h0D,         8'd10}, // R10
    '{1'b0, 12'hFFC, 32'h0,          1'b0, 8'h00, 32'hB1,         8'd10}, // R10
    '{1'b0, 12'h800, 32'h0,          1'b0, 8'h00, 32'h0,          8'd11}  // R11
  };

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        dev_rx_pending;
  logic [7:0]  dev_rx_byte;
  logic        dev_rx_pop;
  logic        dev_tx_valid;
  logic [7:0]  dev_tx_byte;
  logic        irq;

  int checks;
  int fails;
  bit done;

  logic        pop_s;
  logic        tx_s;
  logic [7:0]  txb_s;
  logic [31:0] pre_rdata;

  ps2_port_regs u_ps2_port_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_rd         (bus_rd),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .dev_rx_pending (dev_rx_pending),
    .dev_rx_byte    (dev_rx_byte),
    .dev_rx_pop     (dev_rx_pop),
    .dev_tx_valid   (dev_tx_valid),
    .dev_tx_byte    (dev_tx_byte),
    .irq            (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one bus access; on return the registered read data is valid
  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input bit pend, input logic [7:0] rxb);
    @(negedge clk);
    bus_addr       = a;
    bus_wdata      = d;
    bus_rd         = !wr;
    bus_wr         = wr;
    dev_rx_pending = pend;
    dev_rx_byte    = rxb;
    #1;
    pop_s     = dev_rx_pop;
    tx_s      = dev_tx_valid;
    txb_s     = dev_tx_byte;
    pre_rdata = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n          = 1'b0;
    bus_addr       = '0;
    bus_rd         = 1'b0;
    bus_wr         = 1'b0;
    bus_wdata      = '0;
    dev_rx_pending = 1'b0;
    dev_rx_byte    = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    check("R1 strobes", {30'd0, dev_rx_pop, dev_tx_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      bit exp_pop;
      bit exp_tx;
      string tag;
      tag     = $sformatf("R%0d vec%0d", VECS[i].req, i);
      exp_pop = !VECS[i].wr && VECS[i].addr[11:2] == 10'd2 && VECS[i].pend;
      exp_tx  = VECS[i].wr && VECS[i].addr[11:2] == 10'd2;
      access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].pend, VECS[i].rxb);
      check({tag, " strobes"}, {30'd0, pop_s, tx_s}, {30'd0, exp_pop, exp_tx});
      if (VECS[i].wr) begin
        if (exp_tx) check({tag, " txbyte"}, {24'd0, txb_s}, {24'd0, VECS[i].wdata[7:0]});
      end else begin
        check({tag, " rdata"}, bus_rdata, VECS[i].exp);
      end
    end

    // R9: divisor untouched by ignored writes
    access(1'b0, 12'h00C, 32'h0, 1'b0, 8'h00);
    check("R9 div kept", bus_rdata, 32'h1234_5678);

    // R12: value is not visible during the access cycle, then holds
    access(1'b0, 12'h010, 32'h0, 1'b0, 8'h00);
    check("R12 before edge", pre_rdata, 32'h1234_5678);
    check("R12 after edge", bus_rdata, 32'h2);
    repeat (4) @(negedge clk);
    check("R12 hold", bus_rdata, 32'h2);

    // R3: interrupt level
    access(1'b1, 12'h000, 32'h0000_0008, 1'b0, 8'h00);
    check("R3 force", {31'd0, irq}, 32'd1);
    access(1'b1, 12'h000, 32'h0000_0010, 1'b0, 8'h00);
    check("R3 rx enable no pending", {31'd0, irq}, 32'd0);
    dev_rx_pending = 1'b1;
    #1;
    check("R3 rx enable pending", {31'd0, irq}, 32'd1);
    dev_rx_pending = 1'b0;
    #1;
    check("R3 pending drop", {31'd0, irq}, 32'd0);
    access(1'b1, 12'h000, 32'h0000_0000, 1'b1, 8'h00);
    check("R3 disabled", {31'd0, irq}, 32'd0);

    // R1: reset mid-run clears storage and latched byte
    access(1'b0, 12'h008, 32'h0, 1'b1, 8'h81);
    check("R5 latch before reset", bus_rdata, 32'h81);
    access(1'b1, 12'h000, 32'h0000_0018, 1'b0, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 12'h000, 32'h0, 1'b0, 8'h00);
    check("R1 ctrl after reset", bus_rdata, 32'h0);
    access(1'b0, 12'h008, 32'h0, 1'b0, 8'h00);
    check("R1 byte after reset", bus_rdata, 32'h0);
    access(1'b0, 12'h00C, 32'h0, 1'b0, 8'h00);
    check("R1 div after reset", bus_rdata, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule